// File: doc/BRIEF.md
# Scan-Wrapped Accumulator with Observe and Control Muxes

This block is a small sequential datapath made fully testable from a handful of pins. The datapath holds a `DATA_W`-bit accumulator and a one-bit flag. Each cycle it can either add the input word with the flag as carry, or rotate the accumulator left through the flag and XOR in the input word. Every state bit sits in a mux-input scan cell. All `DATA_W+1` cells form one shift chain, so a tester can load any state, apply one functional clock and read the result back out.

The `scan_mode` pin selects between normal capture and shifting. Shifting out the captured response and shifting in the next state take the same `DATA_W+1` clocks. Two further test muxes open the inside of the block:
- **Observe mux.** `obs_en` routes the combinational next-state value to the output pins in place of the registered state.
- **Control mux.** `ctl_en` lets the `ctl_val` pins replace the accumulator as the operand of the next-state logic.

The reset is asynchronous and active-low, and it is released to the chain through a two-stage synchronizer.

Top module: `scan_wrap`

## Requirements
- R1: While `rst_n` is low, every chain cell is cleared. `dout`, `flag` and `scan_out` read 0 when `obs_en` is 0, and `scan_mode` and `step` have no effect.
- R2: With `scan_mode`=1, each clock moves the chain one place toward the last cell and loads `scan_in` into cell 0. `step`, `op`, `din` and `ctl_en` have no effect.
- R3: Chain order is behaviour. Cells 0..DATA_W-1 are accumulator bits 0..DATA_W-1, and cell DATA_W is the flag. After DATA_W+1 shift clocks, the first bit presented is in the flag cell and the last bit presented is in accumulator bit 0.
- R4: `scan_out` always shows the last cell (the flag). During one shift pass the old state leaves in order from the last cell down to cell 0, while the new state enters.
- R5: With `scan_mode`=0, `step`=1 and `op`=0, one clock captures `{flag, acc} <= operand + din + flag`. The operand is `acc`, or `ctl_val` when `ctl_en`=1.
- R6: With `scan_mode`=0, `step`=1 and `op`=1, one clock captures `flag <= operand[DATA_W-1]` and `acc <= {operand[DATA_W-2:0], flag} ^ din`.
- R7: With `scan_mode`=0 and `step`=0, the chain holds its value whatever `din`, `op` or `scan_in` do.
- R8: With `obs_en`=1, `dout` and `flag` show the combinational next-state accumulator and flag for the present inputs. With `obs_en`=0, they show the registered state.
- R9: With `ctl_en`=1, `ctl_val` replaces the accumulator as the operand in both operations. The flag still comes from its cell.
- R10: After `rst_n` rises, the chain stays cleared for two more rising clock edges. The third edge is the first one that captures.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all cells |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_mode | input | 1 | 1 = shift chain, 0 = functional capture |
| scan_in | input | 1 | Serial data into cell 0 |
| scan_out | output | 1 | Serial data from the last cell |
| step | input | 1 | Functional clock enable |
| op | input | 1 | 0 = add with carry, 1 = rotate through flag and XOR |
| din | input | DATA_W | Functional data word |
| obs_en | input | 1 | Observe mux select |
| ctl_en | input | 1 | Control mux select |
| ctl_val | input | DATA_W | Forced operand when ctl_en is 1 |
| dout | output | DATA_W | Accumulator, or next accumulator when observing |
| flag | output | 1 | Flag, or next flag when observing |

## Verification
The bench targets several corner cases, each tied to a specific wrong design:
- **Chain order.** A known asymmetric pattern is loaded through `scan_in`. A chain wired in reverse would put the first bit into accumulator bit 0 instead of the flag.
- **Overlapped pass.** Unload and load run in the same pass. A cell that took its neighbour's next value, or a `scan_out` taken from the wrong end, would show a wrong bit stream on `scan_out`.
- **Carry paths.** An add that overflows is followed by an add that only consumes the carry, and a rotate moves the top bit into the flag. A dropped carry-in, or a rotate in the wrong direction, gives a different word.
- **Reset release and ignored inputs.** The two-edge delay after reset is checked. So is functional activity during shifting, which a design would wrongly capture if the mode mux favoured the functional data.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic {
    OP_ADDC = 1'b0,
    OP_ROTX = 1'b1
  } op_e;

  localparam int unsigned RST_STAGES = 2;

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/scan_cell.sv
module scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic se,
  input  logic en,
  input  logic d,
  input  logic si,
  output logic q
);

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (se) begin
      q_nxt = si;
    end else if (en) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/scan_next_state.sv
module scan_next_state
  import scan_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic              cin,
  input  op_e               op,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] nxt_acc,
  output logic              nxt_flag
);

  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] rot;

  always_comb begin
    sum = {1'b0, opnd} + {1'b0, din} + {{DATA_W{1'b0}}, cin};
    rot = {opnd[DATA_W-2:0], cin} ^ din;
    unique case (op)
      OP_ADDC: begin
        nxt_acc  = sum[DATA_W-1:0];
        nxt_flag = sum[DATA_W];
      end
      OP_ROTX: begin
        nxt_acc  = rot;
        nxt_flag = opnd[DATA_W-1];
      end
      default: begin
        nxt_acc  = opnd;
        nxt_flag = cin;
      end
    endcase
  end

endmodule

// File: rtl/scan_wrap.sv
module scan_wrap
  import scan_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_mode,
  input  logic              scan_in,
  output logic              scan_out,
  input  logic              step,
  input  logic              op,
  input  logic [DATA_W-1:0] din,
  input  logic              obs_en,
  input  logic              ctl_en,
  input  logic [DATA_W-1:0] ctl_val,
  output logic [DATA_W-1:0] dout,
  output logic              flag
);

  localparam int unsigned CHAIN_N = DATA_W + 1;
  localparam int unsigned FLAG_IX = DATA_W;

  logic                core_rst_n;
  logic [CHAIN_N-1:0]  chain_q;
  logic [CHAIN_N-1:0]  func_d;
  logic [CHAIN_N-1:0]  shift_d;
  logic [DATA_W-1:0]   operand;
  logic [DATA_W-1:0]   nxt_acc;
  logic                nxt_flag;

  scan_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  // control mux: forced operand replaces the accumulator
  always_comb begin
    operand = ctl_en ? ctl_val : chain_q[DATA_W-1:0];
  end

  scan_next_state #(.DATA_W(DATA_W)) u_ns (
    .opnd     (operand),
    .cin      (chain_q[FLAG_IX]),
    .op       (op_e'(op)),
    .din      (din),
    .nxt_acc  (nxt_acc),
    .nxt_flag (nxt_flag)
  );

  always_comb begin
    func_d  = {nxt_flag, nxt_acc};
    shift_d = {chain_q[CHAIN_N-2:0], scan_in};
  end

  for (genvar i = 0; i < CHAIN_N; i++) begin : g_cell
    scan_cell u_cell (
      .clk   (clk),
      .rst_n (core_rst_n),
      .se    (scan_mode),
      .en    (step),
      .d     (func_d[i]),
      .si    (shift_d[i]),
      .q     (chain_q[i])
    );
  end

  // observe mux: next-state value in place of the registered state
  always_comb begin
    if (obs_en) begin
      dout = nxt_acc;
      flag = nxt_flag;
    end else begin
      dout = chain_q[DATA_W-1:0];
      flag = chain_q[FLAG_IX];
    end
  end

  assign scan_out = chain_q[CHAIN_N-1];

endmodule

// File: rtl/scan_wrap_chk.sv
module scan_wrap_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scan_mode,
  input logic              scan_in,
  input logic              step,
  input logic              op,
  input logic [DATA_W-1:0] din,
  input logic              obs_en,
  input logic              ctl_en,
  input logic [DATA_W-1:0] ctl_val,
  input logic [DATA_W-1:0] dout,
  input logic              flag,
  input logic [DATA_W:0]   chain
);

  localparam int unsigned N = DATA_W + 1;

  logic live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
    end else begin
      live_q <= 1'b1;
    end
  end

  p_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (chain == '0));

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && scan_mode) |=> (chain == {$past(chain[N-2:0]), $past(scan_in)}));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !scan_mode && !step) |=> $stable(chain));

  p_addc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !scan_mode && step && !op && !ctl_en) |=>
      (chain == $past({1'b0, chain[DATA_W-1:0]} + {1'b0, din} + {{DATA_W{1'b0}}, chain[DATA_W]})));

  p_rotx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !scan_mode && step && op && !ctl_en) |=>
      (chain == $past({chain[DATA_W-1], {chain[DATA_W-2:0], chain[DATA_W]} ^ din})));

  p_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && !scan_mode && step && !op && ctl_en) |=>
      (chain == $past({1'b0, ctl_val} + {1'b0, din} + {{DATA_W{1'b0}}, chain[DATA_W]})));

  p_plain_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !obs_en |-> ((dout == chain[DATA_W-1:0]) && (flag == chain[DATA_W])));

endmodule

bind scan_wrap scan_wrap_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (core_rst_n),
  .scan_mode (scan_mode),
  .scan_in   (scan_in),
  .step      (step),
  .op        (op),
  .din       (din),
  .obs_en    (obs_en),
  .ctl_en    (ctl_en),
  .ctl_val   (ctl_val),
  .dout      (dout),
  .flag      (flag),
  .chain     (chain_q)
);

// File: tb/sim_scan_wrap.sv
`timescale 1ns/1ps
module sim_scan_wrap;

  localparam int W = 8;
  localparam int N = W + 1;
  localparam realtime CLK_NS = 8.0;

  typedef struct {
    logic [W-1:0] dout;
    logic         flag;
    logic         sout;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         scan_mode, scan_in, step, op, obs_en, ctl_en;
  logic [W-1:0] din, ctl_val;
  logic         scan_out, flag;
  logic [W-1:0] dout;

  exp_t         sb_q[$];
  logic [N-1:0] st_m;
  int           frz;
  int           checks = 0;
  int           fails  = 0;

  always #(CLK_NS/2) clk = ~clk;

  scan_wrap #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .scan_in(scan_in),
    .scan_out(scan_out), .step(step), .op(op), .din(din), .obs_en(obs_en),
    .ctl_en(ctl_en), .ctl_val(ctl_val), .dout(dout), .flag(flag)
  );

  // reference next state, written from the requirements
  function automatic logic [N-1:0] ref_next(logic [N-1:0] s, logic o,
                                            logic [W-1:0] d, logic ce,
                                            logic [W-1:0] cv);
    logic [W-1:0] a;
    logic [N-1:0] r;
    a = ce ? cv : s[W-1:0];
    if (!o) r = {1'b0, a} + {1'b0, d} + N'(s[W]);
    else    r = {a[W-1], ({a[W-2:0], s[W]} ^ d)};
    return r;
  endfunction

  task automatic drive(input logic sm, input logic si, input logic stp,
                       input logic o, input logic [W-1:0] d, input logic ob,
                       input logic ce, input logic [W-1:0] cv, input string tag);
    exp_t e;
    logic [N-1:0] nx;
    @(negedge clk);
    scan_mode = sm; scan_in = si; step = stp; op = o; din = d;
    obs_en = ob; ctl_en = ce; ctl_val = cv;
    if (frz > 0) begin
      frz--;
      st_m = '0;
    end else if (sm) begin
      st_m = {st_m[N-2:0], si};
    end else if (stp) begin
      st_m = ref_next(st_m, o, d, ce, cv);
    end
    nx = ref_next(st_m, o, d, ce, cv);
    e.dout = ob ? nx[W-1:0] : st_m[W-1:0];
    e.flag = ob ? nx[W]     : st_m[W];
    e.sout = st_m[N-1];
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  task automatic shift_word(input logic [N-1:0] pat, input string tag);
    for (int i = N - 1; i >= 0; i--) begin
      drive(1'b1, pat[i], 1'b1, 1'b0, 8'hA5, 1'b0, 1'b1, 8'h0F, tag);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: compares outputs after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (dout !== e.dout || flag !== e.flag || scan_out !== e.sout) begin
          fails++;
          $display("FAIL %s: dout=%h flag=%b sout=%b expected dout=%h flag=%b sout=%b",
                   e.tag, dout, flag, scan_out, e.dout, e.flag, e.sout);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; scan_mode = 1'b0; scan_in = 1'b0; step = 1'b0; op = 1'b0;
    din = '0; obs_en = 1'b0; ctl_en = 1'b0; ctl_val = '0;
    st_m = '0; frz = 1000;

    // R1: held in reset, shift and step attempted
    repeat (3) drive(1'b1, 1'b1, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h00, "R1");

    // R10: release between edges, two edges still cleared
    @(negedge clk);
    rst_n = 1'b1;
    frz = 1;
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0, 8'h00, "R10");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h05, 1'b0, 1'b0, 8'h00, "R10");

    // R5: add overflows into the flag, then carry is consumed
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b0, 1'b0, 8'h00, "R5");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, "R5");

    // R7: hold with busy inputs
    drive(1'b0, 1'b1, 1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, 8'h00, "R7");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 8'h00, "R7");

    // R6: rotate through flag with xor
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 8'h00, "R6");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h81, 1'b0, 1'b0, 8'h00, "R6");

    // R3 and R2: load an asymmetric pattern, functional inputs busy
    shift_word(9'b1_0000_0110, "R3");
    // R8: observe next state with and without a step
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 1'b1, 1'b0, 8'h00, "R8");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h22, 1'b1, 1'b0, 8'h00, "R8");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h22, 1'b0, 1'b0, 8'h00, "R8");

    // R4: unload response while loading next state
    shift_word(9'b0_1111_0001, "R4");
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 1'b0, 1'b0, 8'h00, "R5");
    shift_word(9'b1_1010_1010, "R4");

    // R9: forced operand for add and rotate
    drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 1'b0, 1'b1, 8'h3C, "R9");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 8'h96, "R9");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 8'hF0, "R9");

    // mixed traffic
    for (int k = 0; k < 240; k++) begin
      drive(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
            1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
            8'($urandom), "R2 R5 R6 R7 R8 R9 mix");
    end

    // R1: asynchronous reset mid-run clears the outputs at once
    @(negedge clk);
    obs_en = 1'b0;
    rst_n = 1'b0;
    #1;
    checks++;
    if (dout !== '0 || flag !== 1'b0 || scan_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: dout=%h flag=%b sout=%b expected 00 0 0", dout, flag, scan_out);
    end
    repeat (3) @(posedge clk);
    #3;
    summary();
    $finish;
  end

endmodule